// File: doc/BRIEF.md
# Four-Port Flit Crossbar Switch

This block is a four-input, four-output switch for 8-bit flits, meant for a node of an on-chip network. Each input port feeds its own small FIFO. The flit at the head of each FIFO names its destination output in its two lowest bits. One arbiter per output picks a single winner each clock among the heads that want that output. The winners close points in a 16-line crosspoint matrix, and a purely combinational fabric copies each chosen head onto its output bus in the same cycle.

Flits aimed at different outputs cross the switch together. Flits that collide on one output leave one per clock, and the losers wait in their FIFOs. The output arbiter rotates by default: the input it has just served drops to the lowest priority for that output. A parameter can swap in a fixed-priority arbiter instead. The crosspoint lines are brought out as a port so that a neighbouring block or an observer can see which paths are closed.

Top module: `flit_xbar4`

## Requirements
- R1: The destination of a flit is its bits [1:0]: the value 0, 1, 2 or 3 selects output 0, 1, 2 or 3.
- R2: When input i is forwarded to output o, crosspoint line `xpt_ctrl[4*i+o]` is high and `out_data[8*o +: 8]` equals that input's head flit in the same cycle.
- R3: At most one crosspoint line per output column is high in a cycle. `out_valid[o]` is high exactly when a line in column o is high. `out_data` is zero for an idle output.
- R4: A flit presented with `in_valid` and accepted at a rising edge can appear at its output from the following cycle. With no contention it appears in exactly that cycle.
- R5: Head flits from different inputs aimed at different outputs are all forwarded in the same cycle.
- R6: Only one flit reaches an output per cycle. Whenever at least one head requests an output, one of them is forwarded, so four flits aimed at one output leave in four consecutive cycles.
- R7: With the rotating arbiter, the input just served on an output has the lowest priority on that output next time. Priority then runs upward from the served input plus one, wrapping at 3. After reset each output favours input 0.
- R8: Each input keeps its flits in arrival order. A head that loses arbitration stays put, and the next flit of that input competes in the cycle after its predecessor leaves.
- R9: Each input FIFO holds 4 flits. A flit offered when the FIFO holds 4 and its head is not leaving that cycle is dropped, and `in_overflow[i]` pulses high in that same cycle. If the head is leaving that cycle, the flit is accepted.
- R10: Reset empties all FIFOs, drives every crosspoint line, `out_valid` bit and `out_data` byte to zero, and returns every arbiter to favour input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock shared by FIFOs and arbiters |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 4 | Per-input flit strobe, bit i for input i |
| in_data | input | 32 | Input flits, input i in bits [8*i+7:8*i] |
| out_valid | output | 4 | Per-output flit strobe |
| out_data | output | 32 | Output flits, output o in bits [8*o+7:8*o] |
| xpt_ctrl | output | 16 | Crosspoint lines, line 4*i+o joins input i to output o |
| in_overflow | output | 4 | Per-input pulse when an offered flit is dropped |

## Verification
The bench builds the switch with its default parameters: four ports, 8-bit flits, FIFOs 4 deep and the rotating arbiter. At this shallow depth, four inputs pushing toward one output fill every FIFO within a handful of cycles. That makes the drop rule and the accept-while-draining case easy to reach, alongside the full four-way rotation. A reference model with per-input queues and per-output priority pointers predicts every output, crosspoint line and overflow pulse each cycle. Directed patterns and a long pseudo-random run both use it.

// File: rtl/flit_xbar_pkg.sv
package flit_xbar_pkg;

  // Crosspoint line number for an input/output pair: rows per input.
  function automatic int xpt_line(input int in_port, input int out_port, input int nports);
    return in_port * nports + out_port;
  endfunction

  // Next index around a ring of nports entries.
  function automatic int ring_next(input int idx, input int nports);
    return (idx + 1) % nports;
  endfunction

endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    count;
  logic             full, accept, do_pop;

  assign full      = (count == CW'(DEPTH));
  assign not_empty = (count != '0);
  assign do_pop    = pop && not_empty;
  assign accept    = push && (!full || do_pop);
  assign overflow  = push && full && !do_pop;
  assign head      = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= bump(wr_ptr);
      if (do_pop) rd_ptr <= bump(rd_ptr);
      if (accept && !do_pop)      count <= count + 1'b1;
      else if (!accept && do_pop) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= push_data;
  end

  // R9: occupancy never exceeds the depth
  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R9: a drop is only flagged on a full FIFO, and leaves the count unchanged
  assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> $stable(count));
  // R8: the switch never pops an empty FIFO
  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty);
endmodule

// File: rtl/flit_out_arb.sv
module flit_out_arb #(
  parameter int NPORTS = 4,
  parameter bit ROTATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] req,
  output logic [NPORTS-1:0] gnt
);
  import flit_xbar_pkg::*;
  localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [IW-1:0] favour;
  logic [IW-1:0] win_idx;
  logic          win_any;

  generate
    if (ROTATE) begin : g_rotate
      always_comb begin
        gnt     = '0;
        win_idx = '0;
        win_any = 1'b0;
        for (int k = 0; k < NPORTS; k++) begin
          int cand;
          cand = (int'(favour) + k) % NPORTS;
          if (!win_any && req[cand]) begin
            win_any   = 1'b1;
            win_idx   = IW'(cand);
            gnt[cand] = 1'b1;
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       favour <= '0;
        else if (win_any) favour <= IW'(ring_next(int'(win_idx), NPORTS));
      end
    end else begin : g_fixed
      always_comb begin
        gnt     = '0;
        win_idx = '0;
        win_any = 1'b0;
        for (int k = 0; k < NPORTS; k++) begin
          if (!win_any && req[k]) begin
            win_any = 1'b1;
            win_idx = IW'(k);
            gnt[k]  = 1'b1;
          end
        end
      end
      assign favour = '0;
    end
  endgenerate

  // R6: grants only go to requesters
  assert_grant_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  // R6: any request yields exactly one grant
  assert_work_conserving_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $onehot(gnt));
  // R7: an input granted while a rival waits does not win the next round against it
  assert_served_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ROTATE && $countones(req) == 2 && $onehot(gnt)) |=>
      (($past(req) == req) -> (gnt != $past(gnt))));
endmodule

// File: rtl/flit_fabric.sv
module flit_fabric #(
  parameter int NPORTS = 4,
  parameter int WIDTH  = 8
) (
  input  logic [NPORTS-1:0][WIDTH-1:0]  src_data,
  input  logic [NPORTS*NPORTS-1:0]      lines,
  output logic [NPORTS-1:0][WIDTH-1:0]  dst_data,
  output logic [NPORTS-1:0]             dst_valid
);
  import flit_xbar_pkg::*;

  generate
    for (genvar o = 0; o < NPORTS; o++) begin : g_col
      always_comb begin
        dst_data[o]  = '0;
        dst_valid[o] = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
          if (lines[xpt_line(i, o, NPORTS)]) begin
            dst_data[o]  = dst_data[o] | src_data[i];
            dst_valid[o] = 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/flit_xbar4.sv
module flit_xbar4 #(
  parameter int NPORTS     = 4,
  parameter int FLIT_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter bit ARB_ROTATE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORTS-1:0]          in_valid,
  input  logic [NPORTS*FLIT_W-1:0]   in_data,
  output logic [NPORTS-1:0]          out_valid,
  output logic [NPORTS*FLIT_W-1:0]   out_data,
  output logic [NPORTS*NPORTS-1:0]   xpt_ctrl,
  output logic [NPORTS-1:0]          in_overflow
);
  import flit_xbar_pkg::*;
  localparam int DEST_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [NPORTS-1:0][FLIT_W-1:0] heads;
  logic [NPORTS-1:0]             head_ok;
  logic [NPORTS-1:0]             pop;
  logic [NPORTS-1:0][NPORTS-1:0] req_by_out;   // [out][in]
  logic [NPORTS-1:0][NPORTS-1:0] gnt_by_out;   // [out][in]
  logic [NPORTS-1:0][FLIT_W-1:0] fab_data;

  generate
    for (genvar i = 0; i < NPORTS; i++) begin : g_in
      flit_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid[i]),
        .push_data (in_data[i*FLIT_W +: FLIT_W]),
        .pop       (pop[i]),
        .head      (heads[i]),
        .not_empty (head_ok[i]),
        .overflow  (in_overflow[i])
      );

      // row of crosspoint lines owned by this input
      logic [NPORTS-1:0] row;
      for (genvar o = 0; o < NPORTS; o++) begin : g_req
        assign req_by_out[o][i] = head_ok[i] &&
                                  (int'(heads[i][DEST_W-1:0]) == o);
        assign xpt_ctrl[xpt_line(i, o, NPORTS)] = gnt_by_out[o][i];
        assign row[o] = xpt_ctrl[xpt_line(i, o, NPORTS)];
      end
      assign pop[i] = |row;

      // R2: an input is switched to at most one output
      assert_row_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row));
      // R8: an input whose head is waiting keeps presenting the same flit
      assert_head_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (head_ok[i] && !pop[i]) |=> (head_ok[i] && $stable(heads[i])));
    end

    for (genvar o = 0; o < NPORTS; o++) begin : g_out
      flit_out_arb #(.NPORTS(NPORTS), .ROTATE(ARB_ROTATE)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_by_out[o]),
        .gnt   (gnt_by_out[o])
      );

      logic [NPORTS-1:0] col;
      for (genvar i = 0; i < NPORTS; i++) begin : g_col
        assign col[i] = xpt_ctrl[xpt_line(i, o, NPORTS)];
      end

      // R3: one line per output column
      assert_one_per_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col));
      // R3: output strobe follows its column
      assert_valid_matches_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] == (|col));
    end
  endgenerate

  flit_fabric #(.NPORTS(NPORTS), .WIDTH(FLIT_W)) u_fabric (
    .src_data  (heads),
    .lines     (xpt_ctrl),
    .dst_data  (fab_data),
    .dst_valid (out_valid)
  );

  assign out_data = fab_data;

  // R10: with every FIFO empty no crosspoint is closed
  assert_idle_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (head_ok == '0) |-> (xpt_ctrl == '0));
endmodule

// File: tb/flit_xbar4_bench.sv
`timescale 1ns/1ps
module flit_xbar4_bench;
  localparam int N = 4;
  localparam int W = 8;
  localparam int D = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0]   out_valid;
  logic [N*W-1:0] out_data;
  logic [N*N-1:0] xpt_ctrl;
  logic [N-1:0]   in_overflow;

  flit_xbar4 u_flit_xbar4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .xpt_ctrl(xpt_ctrl),
    .in_overflow(in_overflow)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // scoreboard state: per-input expected queues, per-output favoured input
  logic [W-1:0] sb_q [N][$];
  int           fav [N];
  logic [31:0]  lfsr = 32'h1ACE_B00C;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic sb_clear();
    for (int i = 0; i < N; i++) begin
      sb_q[i].delete();
      fav[i] = 0;
    end
  endtask

  // One cycle: drive inputs at the falling edge, compare the design against
  // the scoreboard, then advance the scoreboard to what the next rising edge does.
  task automatic cycle(input logic [N-1:0] v, input logic [N*W-1:0] d);
    logic [N*N-1:0] exp_lines;
    logic [N-1:0]   exp_valid, popped, exp_ovf;
    logic [N*W-1:0] exp_data;
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    #1;
    exp_lines = '0; exp_valid = '0; exp_data = '0; popped = '0;
    for (int o = 0; o < N; o++) begin
      for (int k = 0; k < N; k++) begin
        int src;
        src = (fav[o] + k) % N;
        // R1: bits [1:0] name the output; R7: scan from the favoured input
        if (!exp_valid[o] && sb_q[src].size() > 0 && int'(sb_q[src][0][1:0]) == o) begin
          exp_valid[o] = 1'b1;
          exp_data[o*W +: W] = sb_q[src][0];
          exp_lines[src*N + o] = 1'b1;
          popped[src] = 1'b1;
        end
      end
    end
    exp_ovf = '0;
    for (int i = 0; i < N; i++)
      exp_ovf[i] = v[i] && sb_q[i].size() == D && !popped[i];

    check(out_valid == exp_valid, "R3/R5/R6", "out_valid", 32'(out_valid), 32'(exp_valid));
    check(xpt_ctrl == exp_lines, "R2/R7", "xpt_ctrl", 32'(xpt_ctrl), 32'(exp_lines));
    check(out_data == exp_data, "R2/R8", "out_data", out_data, exp_data);
    check(in_overflow == exp_ovf, "R9", "in_overflow", 32'(in_overflow), 32'(exp_ovf));

    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        if (exp_lines[i*N + o]) begin
          void'(sb_q[i].pop_front());
          fav[o] = (i + 1) % N;
        end
    for (int i = 0; i < N; i++)
      if (v[i] && !exp_ovf[i]) sb_q[i].push_back(d[i*W +: W]);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) cycle('0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0;
    sb_clear();
    @(negedge clk);
    #1;
    // R10: everything idle under reset
    check(xpt_ctrl == '0, "R10", "xpt_ctrl in reset", 32'(xpt_ctrl), 32'h0);
    check(out_valid == '0, "R10", "out_valid in reset", 32'(out_valid), 32'h0);
    check(out_data == '0, "R10", "out_data in reset", out_data, 32'h0);
    rst_n = 1'b1;
  endtask

  function automatic logic [W-1:0] mk(input int tagv, input int dst);
    return W'((tagv << 2) | (dst & 3));
  endfunction

  function automatic logic [N*W-1:0] pack4(input logic [W-1:0] a, b, c, e);
    return {e, c, b, a};
  endfunction

  initial begin
    do_reset();
    idle(2);

    // R1 R4 R5: four distinct destinations, all crossing together one cycle later
    cycle(4'hF, pack4(mk(1, 0), mk(2, 1), mk(3, 2), mk(4, 3)));
    cycle('0, '0);
    idle(2);

    // R5: permuted destinations (input i -> output 3-i)
    cycle(4'hF, pack4(mk(5, 3), mk(6, 2), mk(7, 1), mk(8, 0)));
    idle(3);

    // R6 R7: inputs 0 and 1 both to output 0, inputs 2,3 to outputs 1,2
    cycle(4'hF, pack4(mk(9, 0), mk(10, 0), mk(11, 1), mk(12, 2)));
    idle(3);

    // R6 R7: all four to output 3, four cycles to drain, rotation visible
    cycle(4'hF, pack4(mk(13, 3), mk(14, 3), mk(15, 3), mk(16, 3)));
    idle(5);
    cycle(4'hF, pack4(mk(17, 3), mk(18, 3), mk(19, 3), mk(20, 3)));
    idle(5);

    // R8 R9: all inputs flood output 0 so FIFOs fill and drop
    for (int c = 0; c < 12; c++)
      cycle(4'hF, pack4(mk(c, 0), mk(c + 16, 0), mk(c + 32, 0), mk(c + 48, 0)));
    idle(20);

    // R10: reset in the middle of traffic empties everything
    for (int c = 0; c < 6; c++)
      cycle(4'hF, pack4(mk(c, 1), mk(c + 8, 1), mk(c + 16, 2), mk(c + 24, 1)));
    do_reset();
    idle(3);

    // mixed pseudo-random traffic across all requirements
    for (int c = 0; c < 400; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cycle(lfsr[3:0] & lfsr[7:4], {lfsr[31:8], lfsr[7:0] ^ lfsr[15:8]});
    end
    idle(24);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule